// File: doc/BRIEF.md
# Time-Slot Transfer Interrupt Unit

This block tells a microcontroller when it may touch the data registers tied to four time slots of a TDM frame. It follows a frame sync and counts data-clock (DCL) cycles to know the current slot. One bit-clock (BCL) period is two DCL cycles and one slot is eight BCL periods. Each of the four channels (indices 0..3 here, standing for channels 10, 11, 20 and 21) has a programmable slot select and a data-position bit. These decide when its transfer interrupt is raised and when the controller's acknowledge deadline falls. A controller that does not acknowledge a transfer interrupt in time gets an overflow interrupt for that channel.

The controller reaches the block through a small register port. It programs the per-channel slot and position, a mask register and write-1-to-set acknowledge bits. It reads a status register, and that read clears the status. A single summary interrupt output is the OR of all pending status bits that are not masked. The design clock is the DCL, so the block sees one clock edge per DCL cycle.

Top module: `tsti_unit`

## Requirements
- R1: A frame-sync pulse sets the DCL position to 0 on the next edge. After that the position advances by one each clock and wraps at 512. Slot n covers positions 16n to 16n+15.
- R2: With the data-position bit at 0, a channel's transfer event occurs at position 16·slot+20, which is two BCL after its slot ends. The channel's status bit (status bit c) is set on that edge.
- R3: With the data-position bit at 1, the transfer event occurs at position 16·slot+18, one BCL after the slot.
- R4: Event and deadline positions are taken modulo 512. For slot 31 the transfer event therefore falls at the start of the next frame.
- R5: A channel's overflow deadline is at position 16·slot−2 (data-position bit 0) or 16·slot (bit 1), modulo 512. If the channel is armed and its acknowledge bit is clear there, status bit 4+c is set. Every deadline disarms the channel.
- R6: Writing address 5 sets acknowledge bit c for every 1 in data bit c. A channel's transfer event clears its acknowledge bit. When both happen on the same edge, the write wins. Reading address 5 returns the acknowledge bits.
- R7: Mask register (address 4): bit c masks the transfer event of channel c and bit 4+c masks its overflow. A masked event sets no status bit. A transfer event arms its channel only when both of that channel's mask bits are 0.
- R8: Reading status (address 6) returns bits [3:0] transfer and [7:4] overflow. The read clears every bit except one whose event occurs on the same edge.
- R9: The summary interrupt output equals the OR of status AND NOT mask. It falls in the cycle after a clearing read if no event coincides with that read.
- R10: Addresses 0..3 hold channel c's slot in bits [4:0] and its data-position bit in bit 5, and read back the same way. After reset the mask reads 0xFF and configuration, acknowledge and status read 0. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock (one DCL per cycle) |
| rstN | input | 1 | Active-low synchronous reset |
| frameSync | input | 1 | Frame start pulse |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (status read clears) |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, combinational from address |
| irqOut | output | 1 | Summary interrupt |

## Verification
The bench uses the default parameters: 5-bit slot selects, 2 DCL per BCL and 8 BCL per slot. That gives a 512-cycle frame, so many full frames fit in a short run. Slot 31, whose transfer event crosses into the next frame, is reachable within each frame. Overflow deadlines that fall before an acknowledge can be reached as well. Status reads and acknowledge writes are repeated every cycle over some stretches. This makes them collide with transfer events and deadlines, which exercises the same-edge priority rules.

// File: rtl/tsti_pkg.sv
package tsti_pkg;
  // four channels: index 0..3 stands for channels 10, 11, 20, 21
  localparam int NUM_CH = 4;

  localparam int ADDR_MASK = 4;
  localparam int ADDR_ACK  = 5;
  localparam int ADDR_STAT = 6;

  // strobes from the timing datapath to the interrupt control
  typedef struct packed {
    logic [NUM_CH-1:0] xfer;  // transfer point reached
    logic [NUM_CH-1:0] dead;  // acknowledge deadline reached
  } evStrobe_t;
endpackage

// File: rtl/tsti_timing.sv
module tsti_timing
  import tsti_pkg::*;
#(
  parameter int SLOT_W       = 5,
  parameter int DCL_PER_BCL  = 2,
  parameter int BCL_PER_SLOT = 8,
  parameter int POS_W        = SLOT_W + $clog2(DCL_PER_BCL * BCL_PER_SLOT)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           frameSync,
  input  logic [NUM_CH-1:0][SLOT_W-1:0]  slotSel,
  input  logic [NUM_CH-1:0]              dpsSel,
  output logic [POS_W-1:0]               pos,
  output evStrobe_t                      evs
);
  localparam int SLOT_DCL = DCL_PER_BCL * BCL_PER_SLOT;
  localparam logic [POS_W-1:0] OFS_NEAR   = POS_W'(SLOT_DCL + DCL_PER_BCL);
  localparam logic [POS_W-1:0] OFS_FAR    = POS_W'(SLOT_DCL + 2 * DCL_PER_BCL);
  localparam logic [POS_W-1:0] DEAD_EARLY = POS_W'(DCL_PER_BCL);

  always_ff @(posedge clk) begin
    if (!rstN)          pos <= '0;
    else if (frameSync) pos <= '0;
    else                pos <= pos + 1'b1;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [POS_W-1:0] base;
    logic [POS_W-1:0] xferPos;
    logic [POS_W-1:0] deadPos;

    always_comb begin
      base    = POS_W'(POS_W'(slotSel[c]) * POS_W'(SLOT_DCL));
      xferPos = base + (dpsSel[c] ? OFS_NEAR : OFS_FAR);
      deadPos = base - (dpsSel[c] ? '0 : DEAD_EARLY);
    end

    assign evs.xfer[c] = (pos == xferPos);
    assign evs.dead[c] = (pos == deadPos);
  end
endmodule

// File: rtl/tsti_ctrl.sv
module tsti_ctrl
  import tsti_pkg::*;
#(
  parameter int SLOT_W = 5,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           regWrEn,
  input  logic                           regRdEn,
  input  logic [ADDR_W-1:0]              regAddr,
  input  logic [DATA_W-1:0]              regWrData,
  input  evStrobe_t                      evs,
  output logic [DATA_W-1:0]              regRdData,
  output logic                           irqOut,
  output logic [NUM_CH-1:0][SLOT_W-1:0]  slotSel,
  output logic [NUM_CH-1:0]              dpsSel,
  output logic [2*NUM_CH-1:0]            maskBits,
  output logic [NUM_CH-1:0]              ackBits
);
  logic [NUM_CH-1:0]   armed;
  logic [2*NUM_CH-1:0] status;
  logic                maskWr, ackWr, statRd;
  logic [NUM_CH-1:0]   xferMask, overMask, newXfer, newOver;

  assign maskWr = regWrEn && regAddr == ADDR_W'(ADDR_MASK);
  assign ackWr  = regWrEn && regAddr == ADDR_W'(ADDR_ACK);
  assign statRd = regRdEn && regAddr == ADDR_W'(ADDR_STAT);

  assign xferMask = maskBits[NUM_CH-1:0];
  assign overMask = maskBits[2*NUM_CH-1:NUM_CH];
  assign newXfer  = evs.xfer & ~xferMask;
  assign newOver  = evs.dead & armed & ~ackBits & ~overMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotSel  <= '0;
      dpsSel   <= '0;
      maskBits <= '1;
      ackBits  <= '0;
      armed    <= '0;
      status   <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (regWrEn && regAddr == ADDR_W'(c)) begin
          slotSel[c] <= regWrData[SLOT_W-1:0];
          dpsSel[c]  <= regWrData[SLOT_W];
        end
      end
      if (maskWr) maskBits <= regWrData[2*NUM_CH-1:0];
      ackBits <= (ackBits & ~evs.xfer) | (ackWr ? regWrData[NUM_CH-1:0] : '0);
      armed   <= (armed & ~evs.dead) | (newXfer & ~overMask);
      status  <= (statRd ? '0 : status) | {newOver, newXfer};
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr < ADDR_W'(NUM_CH)) begin
      for (int c = 0; c < NUM_CH; c++)
        if (regAddr == ADDR_W'(c)) regRdData = DATA_W'({dpsSel[c], slotSel[c]});
    end else if (regAddr == ADDR_W'(ADDR_MASK)) regRdData = DATA_W'(maskBits);
    else if (regAddr == ADDR_W'(ADDR_ACK))      regRdData = DATA_W'(ackBits);
    else if (regAddr == ADDR_W'(ADDR_STAT))     regRdData = DATA_W'(status);
  end

  assign irqOut = |(status & ~maskBits);
endmodule

// File: rtl/tsti_unit.sv
module tsti_unit
  import tsti_pkg::*;
#(
  parameter int SLOT_W       = 5,
  parameter int DCL_PER_BCL  = 2,
  parameter int BCL_PER_SLOT = 8,
  parameter int ADDR_W       = 3,
  parameter int DATA_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameSync,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  localparam int POS_W = SLOT_W + $clog2(DCL_PER_BCL * BCL_PER_SLOT);

  logic [NUM_CH-1:0][SLOT_W-1:0] slotSel;
  logic [NUM_CH-1:0]             dpsSel;
  logic [POS_W-1:0]              pos;
  logic [2*NUM_CH-1:0]           maskBits;
  logic [NUM_CH-1:0]             ackBits;
  evStrobe_t                     evs;

  tsti_timing #(
    .SLOT_W(SLOT_W), .DCL_PER_BCL(DCL_PER_BCL),
    .BCL_PER_SLOT(BCL_PER_SLOT), .POS_W(POS_W)
  ) u_timing (
    .clk(clk), .rstN(rstN), .frameSync(frameSync),
    .slotSel(slotSel), .dpsSel(dpsSel), .pos(pos), .evs(evs)
  );

  tsti_ctrl #(.SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .evs(evs),
    .regRdData(regRdData), .irqOut(irqOut), .slotSel(slotSel),
    .dpsSel(dpsSel), .maskBits(maskBits), .ackBits(ackBits)
  );
endmodule

// File: rtl/tsti_unit_chk.sv
module tsti_unit_chk
  import tsti_pkg::*;
#(
  parameter int POS_W  = 9,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                frameSync,
  input logic                regWrEn,
  input logic                regRdEn,
  input logic [ADDR_W-1:0]   regAddr,
  input logic                irqOut,
  input logic [POS_W-1:0]    pos,
  input logic [NUM_CH-1:0]   evXfer,
  input logic [NUM_CH-1:0]   evDead,
  input logic [2*NUM_CH-1:0] maskBits,
  input logic [NUM_CH-1:0]   ackBits
);
  logic statRd, ackWr;
  assign statRd = regRdEn && regAddr == ADDR_W'(ADDR_STAT);
  assign ackWr  = regWrEn && regAddr == ADDR_W'(ADDR_ACK);

  // R1
  sync_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |=> pos == '0);

  // R1
  pos_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameSync |=> pos == $past(pos) + 1'b1);

  // R2
  xfer_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(evXfer & ~maskBits[NUM_CH-1:0]) && !(maskWr())) |=> irqOut);

  // R5
  apart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evXfer & evDead) == '0);

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|evXfer && !ackWr) |=> (ackBits & $past(evXfer)) == '0);

  // R8
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statRd && evXfer == '0 && evDead == '0) |=> !irqOut);

  function automatic logic maskWr();
    return regWrEn && regAddr == ADDR_W'(ADDR_MASK);
  endfunction
endmodule

bind tsti_unit tsti_unit_chk #(.POS_W(POS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .frameSync(frameSync), .regWrEn(regWrEn),
  .regRdEn(regRdEn), .regAddr(regAddr), .irqOut(irqOut), .pos(pos),
  .evXfer(evs.xfer), .evDead(evs.dead), .maskBits(maskBits), .ackBits(ackBits)
);

// File: tb/tsti_unit_tb.sv
module tsti_unit_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameSync = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regRdEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       irqOut;

  int checks = 0;
  int errors = 0;
  string phase = "R10";
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  tsti_unit u_dut (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  // behavioural reference model
  int       mPos;
  int       mSlot [4];
  bit       mDps [4];
  bit [7:0] mMask, mStat;
  bit [3:0] mAck, mArm;

  function automatic int xferAt(int c);
    return (mSlot[c] * 16 + 16 + (mDps[c] ? 2 : 4)) % 512;
  endfunction
  function automatic int deadAt(int c);
    return (mSlot[c] * 16 - (mDps[c] ? 0 : 2) + 512) % 512;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPos = 0; mMask = 8'hFF; mStat = 0; mAck = 0; mArm = 0;
      for (int c = 0; c < 4; c++) begin mSlot[c] = 0; mDps[c] = 0; end
    end else begin
      bit [3:0] hx, hd, nAck, nArm;
      bit [7:0] nStat;
      for (int c = 0; c < 4; c++) begin
        hx[c] = (mPos == xferAt(c));
        hd[c] = (mPos == deadAt(c));
      end
      nStat = (regRdEn && regAddr == 3'd6) ? 8'h00 : mStat;
      nAck = mAck;
      nArm = mArm;
      for (int c = 0; c < 4; c++) begin
        if (hd[c]) begin
          if (mArm[c] && !mAck[c] && !mMask[4+c]) nStat[4+c] = 1'b1;
          nArm[c] = 1'b0;
        end
        if (hx[c]) begin
          nAck[c] = 1'b0;
          if (!mMask[c]) begin
            nStat[c] = 1'b1;
            if (!mMask[4+c]) nArm[c] = 1'b1;
          end
        end
      end
      if (regWrEn && regAddr == 3'd5) nAck = nAck | regWrData[3:0];
      if (regWrEn && regAddr == 3'd4) mMask = regWrData;
      if (regWrEn && regAddr < 3'd4) begin
        mSlot[regAddr] = int'(regWrData[4:0]);
        mDps[regAddr]  = regWrData[5];
      end
      mStat = nStat; mAck = nAck; mArm = nArm;
      mPos = frameSync ? 0 : (mPos + 1) % 512;
    end
  end

  function automatic bit [7:0] modelRead(logic [2:0] a);
    case (a)
      3'd4: return mMask;
      3'd5: return {4'h0, mAck};
      3'd6: return mStat;
      3'd7: return 8'h00;
      default: return {2'b00, mDps[a], 5'(mSlot[a])};
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // summary interrupt compared on every clock
  always @(negedge clk) begin
    if (rstN && !done) begin
      bit expIrq;
      expIrq = |(mStat & ~mMask);
      chk(irqOut == expIrq, {"R9 irq ", phase}, irqOut, expIrq);
    end
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      regWrEn = 0; regRdEn = 0; frameSync = 0;
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    regRdEn = 0; frameSync = 0;
    regWrEn = 1; regAddr = a; regWrData = d;
  endtask

  task automatic rd(logic [2:0] a, string tag);
    @(negedge clk);
    regWrEn = 0; frameSync = 0;
    regRdEn = 1; regAddr = a;
    #2;
    chk(regRdData == modelRead(a), tag, regRdData, modelRead(a));
  endtask

  task automatic sync();
    @(negedge clk);
    regWrEn = 0; regRdEn = 0;
    frameSync = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    #2;
    chk(irqOut == 1'b0, "R9 reset irq", irqOut, 0);
    chk(regRdData == 8'h00, "R10 reset cfg0", regRdData, 0);
    rd(3'd4, "R10 reset mask");
    chk(regRdData == 8'hFF, "R10 mask is FF", regRdData, 8'hFF);
    rd(3'd6, "R8 reset status");
    rd(3'd5, "R10 reset ack");
    rd(3'd7, "R10 unused addr");

    // R1 R3: slot 0, dps 1, only channel 0 transfer unmasked
    phase = "R1";
    wr(3'd0, 8'h20);
    wr(3'd4, 8'hFE);
    rd(3'd6, "R8 clear");
    sync();
    idle(1);
    idle(18);
    chk(irqOut == 1'b0, "R1 R3 before event", irqOut, 0);
    idle(1);
    chk(irqOut == 1'b1, "R1 R3 after event", irqOut, 1);
    rd(3'd6, "R3 status bit0");
    idle(1);
    #2;
    chk(irqOut == 1'b0, "R9 falls after read", irqOut, 0);

    // R2 R3 R4: transfer events only, mixed slots and positions
    phase = "R2 R3 R4";
    wr(3'd0, 8'h03);
    wr(3'd1, 8'h23);
    wr(3'd2, 8'h1F);
    wr(3'd3, 8'h2A);
    for (int a = 0; a < 4; a++) rd(3'(a), "R10 cfg readback");
    wr(3'd4, 8'hF0);
    sync();
    for (int i = 0; i < 50; i++) begin
      idle(11);
      rd(3'd6, "R2 R3 R4 status");
    end

    // R5 R6: everything unmasked, acks on some channels only
    phase = "R5 R6";
    wr(3'd4, 8'h00);
    for (int i = 0; i < 60; i++) begin
      idle(13);
      if (i % 3 == 0) wr(3'd5, 8'h05);
      rd(3'd5, "R6 ack readback");
      rd(3'd6, "R5 status");
    end
    // acknowledge written every cycle across transfer points
    for (int i = 0; i < 600; i++) wr(3'd5, 8'h0F);
    rd(3'd5, "R6 ack wins");
    for (int i = 0; i < 30; i++) begin
      idle(17);
      rd(3'd6, "R5 R6 status");
    end

    // R7: transfer masked (no arming), then overflow masked
    phase = "R7";
    wr(3'd4, 8'h0F);
    for (int i = 0; i < 45; i++) begin
      idle(23);
      rd(3'd6, "R7 status xfer masked");
    end
    wr(3'd4, 8'hA5);
    for (int i = 0; i < 45; i++) begin
      idle(23);
      rd(3'd6, "R7 status mixed mask");
    end

    // R8: status read every cycle so reads coincide with events
    phase = "R8";
    wr(3'd4, 8'h00);
    for (int i = 0; i < 1100; i++) rd(3'd6, "R8 read vs event");

    // R1: realign mid-frame
    phase = "R1 realign";
    idle(137);
    sync();
    for (int i = 0; i < 40; i++) begin
      idle(19);
      rd(3'd6, "R1 status after resync");
    end

    idle(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", 1, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule